// File: doc/BRIEF.md
# Dual-Pattern Overlapping Sequence Recognizer

This block watches a one-bit serial stream, sampled on every rising clock edge, and raises a single match flag whenever the four most recent samples form one of two fixed patterns. The first pattern is four ones in a row. The second pattern is one, one, zero, one, read from the oldest sample to the newest. Matches can overlap. A long run of ones, for example, keeps the flag high on every edge from the fourth one onward. A match can also reuse trailing samples of a previous match as the start of the next one.

The recognizer is a Moore state machine with seven binary-encoded states. Each state records the longest tail of the stream that is still the start of a pattern. The match flag is decoded from the current state alone, so it changes only on clock edges. A synchronous active-high reset returns the machine to the state in which nothing has been matched. Samples taken while reset is asserted are discarded. The unused eighth encoding leads back to that state on the next edge.

Top module: `seqrec_top`

## Requirements
- R1: While `rst` is high at a rising edge, the machine goes to its empty state. After that edge `match_out` is 0, and samples taken during reset count toward no later match.
- R2: `match_out` is 1 after an edge when the last four samples taken since reset, oldest first, are 1,1,1,1.
- R3: `match_out` is 1 after an edge when the last four samples taken since reset, oldest first, are 1,1,0,1.
- R4: In every other case `match_out` is 0 after the edge. This includes every case with fewer than four samples since reset and every edge that samples a 0.
- R5: Matches overlap. A run of N ones (N ≥ 4) gives `match_out` = 1 after the 4th through the Nth edge of the run.
- R6: The final 1 of a 1,1,0,1 match is reused. Following it with 1,0,1 gives a second 1,1,0,1 match on the third of those edges. Following it with 1,1,1 gives a 1,1,1,1 match on the third of those edges, and no match on the first two.
- R7: `match_out` depends only on the state. A change of `bit_in` between clock edges does not change `match_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; `bit_in` is sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data sample |
| match_out | output | 1 | High while the last four samples form either pattern |

## Verification
The block has no parameters, so the bench builds it exactly as it ships. Its reference model keeps the samples taken since the last reset in a queue and decides a match from the newest four entries. This makes short histories, resets in the middle of the stream and overlapping matches checkable without any knowledge of the state encoding. Hand-written sequences cover the reuse paths after each kind of match. A long pseudo-random stream, compared on every edge, reaches every state transition. Input changes between edges test the Moore property.

// File: rtl/seqrec_pkg.sv
package seqrec_pkg;

    localparam int STATE_W = 3;

    // Each state names the longest stream tail that is still a pattern prefix.
    typedef enum logic [STATE_W-1:0] {
        ST_EMPTY     = 3'd0,  // no useful tail
        ST_ONE       = 3'd1,  // tail 1
        ST_ONE_ONE   = 3'd2,  // tail 11
        ST_ONE_ONE_Z = 3'd3,  // tail 110
        ST_THREE     = 3'd4,  // tail 111
        ST_HIT_RUN   = 3'd5,  // tail 1111, match
        ST_HIT_GAP   = 3'd6   // tail 1101, match
    } rec_state_e;

    function automatic rec_state_e advance(input rec_state_e cur, input logic b);
        rec_state_e nxt;
        case (cur)
            ST_EMPTY:     nxt = b ? ST_ONE     : ST_EMPTY;
            ST_ONE:       nxt = b ? ST_ONE_ONE : ST_EMPTY;
            ST_ONE_ONE:   nxt = b ? ST_THREE   : ST_ONE_ONE_Z;
            ST_THREE:     nxt = b ? ST_HIT_RUN : ST_ONE_ONE_Z;
            ST_ONE_ONE_Z: nxt = b ? ST_HIT_GAP : ST_EMPTY;
            ST_HIT_RUN:   nxt = b ? ST_HIT_RUN : ST_ONE_ONE_Z;
            ST_HIT_GAP:   nxt = b ? ST_ONE_ONE : ST_EMPTY;
            default:      nxt = ST_EMPTY;
        endcase
        return nxt;
    endfunction

    function automatic logic is_hit(input rec_state_e s);
        return (s == ST_HIT_RUN) || (s == ST_HIT_GAP);
    endfunction

endpackage

// File: rtl/seqrec_next.sv
module seqrec_next
    import seqrec_pkg::*;
(
    input  rec_state_e cur_state,
    input  logic       sample,
    output rec_state_e nxt_state
);
    always_comb begin
        nxt_state = advance(cur_state, sample);
    end
endmodule

// File: rtl/seqrec_state_reg.sv
module seqrec_state_reg
    import seqrec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rec_state_e d,
    output rec_state_e q
);
    always_ff @(posedge clk) begin
        if (rst) q <= ST_EMPTY;
        else     q <= d;
    end

    // R1: reset leaves the machine empty
    a_r1_reset_empties: assert property (@(posedge clk) rst |=> (q == ST_EMPTY));
endmodule

// File: rtl/seqrec_out.sv
module seqrec_out
    import seqrec_pkg::*;
(
    input  rec_state_e state,
    output logic       hit
);
    always_comb begin
        hit = is_hit(state);
    end
endmodule

// File: rtl/seqrec_top.sv
module seqrec_top
    import seqrec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic match_out
);
    rec_state_e state_q;
    rec_state_e state_d;

    seqrec_next u_next (
        .cur_state (state_q),
        .sample    (bit_in),
        .nxt_state (state_d)
    );

    seqrec_state_reg u_reg (
        .clk (clk),
        .rst (rst),
        .d   (state_d),
        .q   (state_q)
    );

    seqrec_out u_out (
        .state (state_q),
        .hit   (match_out)
    );

    // R1: no match right after reset
    a_r1_no_hit_after_reset: assert property (@(posedge clk) rst |=> !match_out);
    // R2: a fourth consecutive one ends in a match
    a_r2_fourth_one: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_THREE && bit_in) |=> match_out);
    // R3: 110 followed by 1 ends in a match
    a_r3_gap_pattern: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ONE_ONE_Z && bit_in) |=> (match_out && state_q == ST_HIT_GAP));
    // R4: a sampled zero never completes a pattern
    a_r4_zero_no_hit: assert property (@(posedge clk) disable iff (rst)
        !bit_in |=> !match_out);
    // R5: a run match keeps matching while ones continue
    a_r5_run_overlap: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HIT_RUN && bit_in) |=> match_out);
    // R6: after a gap match, one more 1 leaves no match
    a_r6_reuse_tail: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HIT_GAP && bit_in) |=> (!match_out && state_q == ST_ONE_ONE));
endmodule

// File: tb/seqrec_top_bench.sv
module seqrec_top_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic match_out;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 1'b0;
    bit hist[$];

    always #2 clk = ~clk;

    seqrec_top u_seqrec_top (
        .clk       (clk),
        .rst       (rst),
        .bit_in    (bit_in),
        .match_out (match_out)
    );

    function automatic logic model_hit();
        int n = hist.size();
        if (n < 4) return 1'b0;
        return hist[n-4] && hist[n-3] && hist[n-1];
    endfunction

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: match_out=%b expected %b (cycle %0d)", req, got, exp, cycles);
        end
    endtask

    task automatic step(input logic b, input string req);
        bit_in = b;
        @(posedge clk);
        #1;
        if (rst) hist.delete();
        else hist.push_back(b);
        check(match_out, model_hit(), req);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(1'b1, "R1");
        step(1'b1, "R1");
        check(match_out, 1'b0, "R1");
        rst = 1'b0;
    endtask

    task automatic seq(input logic [15:0] bits, input int len, input string req);
        for (int i = len - 1; i >= 0; i--) step(bits[i], req);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, got hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        do_reset();

        seq(16'b1111, 4, "R2");
        check(match_out, 1'b1, "R2");
        do_reset();
        seq(16'b11111, 5, "R5");
        check(match_out, 1'b1, "R5");
        seq(16'b111, 3, "R5");
        check(match_out, 1'b1, "R5");
        step(1'b0, "R4");
        check(match_out, 1'b0, "R4");

        do_reset();
        seq(16'b1101, 4, "R3");
        check(match_out, 1'b1, "R3");
        seq(16'b101, 3, "R6");
        check(match_out, 1'b1, "R6");
        seq(16'b11, 2, "R6");
        check(match_out, 1'b0, "R6");
        step(1'b1, "R6");
        check(match_out, 1'b1, "R6");

        do_reset();
        seq(16'b1011, 4, "R4");
        check(match_out, 1'b0, "R4");
        seq(16'b1001, 4, "R4");
        seq(16'b0111, 4, "R4");
        check(match_out, 1'b0, "R4");

        // reset in mid-stream discards the history
        do_reset();
        seq(16'b111, 3, "R1");
        do_reset();
        step(1'b1, "R1");
        check(match_out, 1'b0, "R1");
        seq(16'b111, 3, "R2");
        check(match_out, 1'b1, "R2");

        // Moore output: wiggle input between edges
        bit_in = 1'b0;
        #1;
        check(match_out, 1'b1, "R7");
        bit_in = 1'b1;
        #1;
        check(match_out, 1'b1, "R7");
        step(1'b0, "R7");
        bit_in = 1'b1;
        #1;
        check(match_out, 1'b0, "R7");

        // long pseudo-random stream
        lfsr = 16'hACE1;
        for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[5], "R4");
            if (i == 1000) do_reset();
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule